// File: doc/BRIEF.md
# Byte-Compare Watchdog Timer

This block is a watchdog that sits on a free-running 16-bit counter, treated as a low byte and a high byte. Software sets an 8-bit update offset while the watchdog is stopped. Each refresh write then loads an 8-bit compare register with the counter's current high byte plus that offset. If software fails to refresh in time, the low byte wraps while the high byte equals the compare value, and the block emits a one-cycle reset pulse.

The counter advances on a tick from a small clock-source selector: the system clock divided by 12 or by 4, an external tick pulse, or every system clock. An idle input can freeze the counter when the idle-suspend bit is set. The watchdog starts enabled out of reset. A lock bit keeps it running until the next reset, and the clock-source, idle-suspend and offset settings are frozen while it runs. The reset pulse also returns all of the block's own state to its reset values. Software reaches the block through a plain one-cycle write strobe with a 2-bit address. There is no back-pressure: a write is taken on the clock edge where `wr_en` is high.

Top module: `ctr_watchdog`

## Requirements
- R1: `wdt_rst` is raised only in the cycle after a clock edge where the watchdog is running and either a forced reset is requested (R4) or a counter tick is taken with the low byte at 0xFF while the high byte equals the compare register.
- R2: A write to address 2 (data ignored) loads the compare register with the high byte held before that edge plus the offset, modulo 256. Refresh is accepted whether or not the watchdog runs.
- R3: With a tick on every clock, if the low byte is L just before the refresh edge, `wdt_rst` is first seen 256*offset + 255 - L clock edges after the refresh edge.
- R4: A write to address 3 with bit 0 set raises `wdt_rst` in the next cycle when the watchdog is running. When the watchdog is stopped, the write has no effect.
- R5: Address 0 is the mode register: bit 0 enable, bit 1 lock, bits 4:2 clock source, bit 5 idle suspend. `wdt_running` is enable OR lock. Lock can only be set by a write. Only a reset or a `wdt_rst` pulse clears it.
- R6: With lock clear, writing bit 0 = 0 stops the watchdog. While it is stopped, no counter match produces `wdt_rst`.
- R7: After reset, `count` is 0, `wdt_running` is 1, the offset and the compare register are 0, and the source is sysclk/12. The first `wdt_rst` therefore appears 3072 clocks after reset is released.
- R8: Mode writes made while the watchdog runs (judged before the write) leave the clock-source and idle-suspend fields unchanged.
- R9: When idle suspend is set and `cpu_idle` is high, the counter and its prescaler hold. When idle suspend is clear, `cpu_idle` has no effect.
- R10: Offset writes (address 1) are ignored while the watchdog runs.
- R11: Clock-source codes: 000 gives sysclk/12, 001 gives sysclk/4, 010 gives one tick per clock with `ext_tick` high, and 011 gives a tick on every clock. Codes 100 to 111 behave as sysclk/12.
- R12: `wdt_rst` is a one-cycle pulse. On the same edge that raises it, the counter, prescaler, compare, offset, enable, lock, source and idle fields return to their R7 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 2 | 0 mode, 1 offset, 2 refresh, 3 force flag |
| wr_data | input | 8 | Write data |
| ext_tick | input | 1 | External counter tick, one per high cycle |
| cpu_idle | input | 1 | CPU idle indication |
| count | output | 16 | Counter value, high byte above low byte |
| wdt_running | output | 1 | Watchdog enabled or locked |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
Each result is due on a fixed edge. A taken tick shows in `count` one edge later. A write changes `wdt_running` on its own edge. `wdt_rst` rises on the edge where the overflowing tick or the forced write is taken, and it has fallen again one edge later. The bench drives inputs and reads outputs on the falling edge. Directed checks count rising edges from the write edge to the pulse and compare that count with the R3 and R7 formulas. Rate checks measure `count` deltas over windows that are whole multiples of the divider, taken after a settling interval. A cycle-level model built from the requirements is compared on every falling edge, both during the directed cases and during seeded random writes.

// File: rtl/ctrwdt_pkg.sv
package ctrwdt_pkg;
  typedef enum logic [2:0] {
    CS_DIV12 = 3'd0,
    CS_DIV4  = 3'd1,
    CS_EXT   = 3'd2,
    CS_SYS   = 3'd3
  } clk_src_e;

  localparam logic [1:0] A_MODE    = 2'd0;
  localparam logic [1:0] A_OFFSET  = 2'd1;
  localparam logic [1:0] A_REFRESH = 2'd2;
  localparam logic [1:0] A_FLAG    = 2'd3;

  localparam int B_EN     = 0;
  localparam int B_LOCK   = 1;
  localparam int B_SEL_LO = 2;
  localparam int SEL_W    = 3;
  localparam int B_IDLE   = 5;
  localparam int B_FORCE  = 0;
endpackage

// File: rtl/ctrwdt_prescale.sv
module ctrwdt_prescale
  import ctrwdt_pkg::*;
#(
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [SEL_W-1:0] sel,
  input  logic             suspend,
  input  logic             ext_tick,
  output logic             tick
);
  localparam int PW = $clog2(DIV_SLOW);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] term;
  logic          div_hit;

  always_comb begin
    term    = (sel == CS_DIV4) ? PW'(DIV_FAST - 1) : PW'(DIV_SLOW - 1);
    div_hit = (pre_q >= term);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pre_q <= '0;
    else if (clear)      pre_q <= '0;
    else if (!suspend)   pre_q <= div_hit ? '0 : pre_q + 1'b1;
  end

  always_comb begin
    if (suspend) tick = 1'b0;
    else begin
      case (sel)
        CS_SYS:  tick = 1'b1;
        CS_EXT:  tick = ext_tick;
        default: tick = div_hit;
      endcase
    end
  end

  p_pre_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= PW'(DIV_SLOW - 1));
endmodule

// File: rtl/ctrwdt_counter.sv
module ctrwdt_counter #(
  parameter int LO_W = 8,
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            tick,
  output logic [LO_W-1:0] lo,
  output logic [HI_W-1:0] hi,
  output logic            lo_wrap
);
  localparam int CW = LO_W + HI_W;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (tick)  cnt_q <= cnt_q + 1'b1;
  end

  assign lo      = cnt_q[LO_W-1:0];
  assign hi      = cnt_q[CW-1:LO_W];
  assign lo_wrap = tick && (lo == {LO_W{1'b1}});

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clear && !tick |=> $stable(cnt_q));
endmodule

// File: rtl/ctrwdt_ctrl.sv
module ctrwdt_ctrl
  import ctrwdt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              running,
  output logic [SEL_W-1:0]  sel,
  output logic              idle_sus,
  output logic [OFF_W-1:0]  offset,
  output logic              refresh,
  output logic              force_hit
);
  logic en_q, lock_q;
  logic mode_wr, off_wr;

  assign mode_wr   = wr_en && (wr_addr == A_MODE);
  assign off_wr    = wr_en && (wr_addr == A_OFFSET);
  assign refresh   = wr_en && (wr_addr == A_REFRESH);
  assign force_hit = wr_en && (wr_addr == A_FLAG) && wr_data[B_FORCE];
  assign running   = en_q | lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b1; lock_q <= 1'b0; sel <= CS_DIV12; idle_sus <= 1'b0; offset <= '0;
    end else if (clear) begin
      en_q <= 1'b1; lock_q <= 1'b0; sel <= CS_DIV12; idle_sus <= 1'b0; offset <= '0;
    end else begin
      if (mode_wr) begin
        en_q   <= wr_data[B_EN];
        lock_q <= lock_q | wr_data[B_LOCK];
        if (!running) begin
          sel      <= wr_data[B_SEL_LO +: SEL_W];
          idle_sus <= wr_data[B_IDLE];
        end
      end
      if (off_wr && !running) offset <= wr_data[OFF_W-1:0];
    end
  end

  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q && !clear |=> lock_q && running);
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    running && !clear |=> $stable(sel) && $stable(idle_sus));
  p_offset_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    running && !clear |=> $stable(offset));
endmodule

// File: rtl/ctrwdt_match.sv
module ctrwdt_match #(
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            refresh,
  input  logic [HI_W-1:0] hi,
  input  logic [HI_W-1:0] offset,
  input  logic            lo_wrap,
  input  logic            running,
  input  logic            force_hit,
  output logic            fire
);
  logic [HI_W-1:0] cmp_q;
  logic [HI_W-1:0] next_cmp;

  assign next_cmp = hi + offset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cmp_q <= '0;
    else if (clear)   cmp_q <= '0;
    else if (refresh) cmp_q <= next_cmp;
  end

  assign fire = running && (force_hit || (lo_wrap && (hi == cmp_q)));

  p_refresh_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    refresh && !clear |=> cmp_q == HI_W'($past(hi) + $past(offset)));
endmodule

// File: rtl/ctr_watchdog.sv
module ctr_watchdog
  import ctrwdt_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LO_W     = 8,
  parameter int HI_W     = 8,
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 ext_tick,
  input  logic                 cpu_idle,
  output logic [LO_W+HI_W-1:0] count,
  output logic                 wdt_running,
  output logic                 wdt_rst
);
  logic             running, idle_sus, refresh, force_hit;
  logic [SEL_W-1:0] sel;
  logic [HI_W-1:0]  offset, hi;
  logic [LO_W-1:0]  lo;
  logic             tick, lo_wrap, fire, suspend;

  assign suspend = idle_sus && cpu_idle;

  ctrwdt_ctrl #(.DATA_W(DATA_W), .OFF_W(HI_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clear(fire), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .running(running), .sel(sel), .idle_sus(idle_sus),
    .offset(offset), .refresh(refresh), .force_hit(force_hit)
  );

  ctrwdt_prescale #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(fire), .sel(sel), .suspend(suspend),
    .ext_tick(ext_tick), .tick(tick)
  );

  ctrwdt_counter #(.LO_W(LO_W), .HI_W(HI_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(fire), .tick(tick),
    .lo(lo), .hi(hi), .lo_wrap(lo_wrap)
  );

  ctrwdt_match #(.HI_W(HI_W)) u_match (
    .clk(clk), .rst_n(rst_n), .clear(fire), .refresh(refresh), .hi(hi),
    .offset(offset), .lo_wrap(lo_wrap), .running(running),
    .force_hit(force_hit), .fire(fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdt_rst <= 1'b0;
    else        wdt_rst <= fire;
  end

  assign count       = {hi, lo};
  assign wdt_running = running;

  p_pulse_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> (count == '0) && wdt_running);
  p_fire_needs_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> $past(wdt_running));
  p_suspend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(suspend) && !wdt_rst |-> count == $past(count));
endmodule

// File: tb/ctr_watchdog_tb.sv
module ctr_watchdog_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, wr_en, ext_tick, cpu_idle;
  logic [1:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [15:0] count;
  logic        wdt_running, wdt_rst;

  int checks = 0, errors = 0;
  bit cmp_on = 0, done = 0;

  ctr_watchdog u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_tick(ext_tick), .cpu_idle(cpu_idle), .count(count),
    .wdt_running(wdt_running), .wdt_rst(wdt_rst)
  );

  // reference model written from the requirements
  bit m_en, m_lock, m_idle, m_rst;
  logic [2:0] m_sel;
  logic [7:0] m_off, m_cmp;
  logic [15:0] m_cnt;
  int m_pre;

  task automatic m_defaults();
    m_en = 1; m_lock = 0; m_idle = 0; m_sel = 3'd0; m_off = 8'd0;
    m_cmp = 8'd0; m_cnt = 16'd0; m_pre = 0;
  endtask

  always @(posedge clk) begin : model
    bit run, tk, fire, susp;
    int term;
    if (!rst_n) begin
      m_defaults(); m_rst = 0;
    end else begin
      run  = m_en | m_lock;
      susp = m_idle && cpu_idle;
      term = (m_sel == 3'd1) ? 3 : 11;
      case (m_sel)
        3'd3:    tk = 1;
        3'd2:    tk = ext_tick;
        default: tk = (m_pre >= term);
      endcase
      if (susp) tk = 0;
      fire = run && ((tk && m_cnt[7:0] == 8'hFF && m_cnt[15:8] == m_cmp) ||
                     (wr_en && wr_addr == 2'd3 && wr_data[0]));
      m_rst = fire;
      if (fire) m_defaults();
      else begin
        if (!susp) m_pre = (m_pre >= term) ? 0 : m_pre + 1;
        if (wr_en && wr_addr == 2'd2) m_cmp = m_cnt[15:8] + m_off;
        if (tk) m_cnt = m_cnt + 16'd1;
        if (wr_en && wr_addr == 2'd0) begin
          if (!run) begin m_sel = wr_data[4:2]; m_idle = wr_data[5]; end
          m_en = wr_data[0];
          m_lock = m_lock | wr_data[1];
        end
        if (wr_en && wr_addr == 2'd1 && !run) m_off = wr_data;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R2 model count", count, m_cnt);
      chk("R12 model pulse", wdt_rst, m_rst);
      chk("R5 model running", wdt_running, m_en | m_lock);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    while (!wdt_rst && n < 40000) begin
      @(posedge clk); n++; @(negedge clk);
    end
  endtask

  task automatic delta(input int settle, input int win, output int d);
    logic [15:0] c0;
    repeat (settle) @(negedge clk);
    c0 = count;
    repeat (win) @(negedge clk);
    d = int'(count - c0);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      report();
      $finish;
    end
  end

  initial begin
    int n, d, lo_v;
    bit seen;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; ext_tick = 0; cpu_idle = 0;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1; cmp_on = 1;

    // R7 reset state and default timeout
    chk("R7 count after reset", count, 0);
    chk("R7 running after reset", wdt_running, 1);
    chk("R7 no pulse after reset", wdt_rst, 0);
    wait_pulse(n);
    chk("R7 default timeout edges", n, 3072);
    chk("R12 count cleared on pulse", count, 0);
    @(negedge clk);
    chk("R12 pulse lasts one cycle", wdt_rst, 0);
    repeat (23) @(negedge clk);
    chk("R12 divider back to /12", count, 2);

    // R3 timeout formula, offset 2, tick every clock
    wr(2'd0, 8'h00); wr(2'd0, 8'h0C); wr(2'd1, 8'd2); wr(2'd2, 8'd0); wr(2'd0, 8'h0D);
    lo_v = count[7:0];
    wr(2'd2, 8'd0);
    wait_pulse(n);
    chk("R3 timeout offset 2", n, 512 + 255 - lo_v);

    // R4 forced reset while running
    wr(2'd3, 8'h01);
    chk("R4 forced pulse", wdt_rst, 1);
    @(negedge clk);
    chk("R12 forced pulse single", wdt_rst, 0);

    // R5 lock
    wr(2'd0, 8'h03); wr(2'd0, 8'h00);
    chk("R5 lock keeps running", wdt_running, 1);
    wr(2'd3, 8'h01);
    chk("R5 forced pulse while locked", wdt_rst, 1);
    wr(2'd0, 8'h00);
    chk("R5 lock cleared by pulse", wdt_running, 0);
    wr(2'd3, 8'h01);
    chk("R4 flag ignored when stopped", wdt_rst, 0);

    // R6 stopped watchdog never fires
    wr(2'd0, 8'h0C); wr(2'd2, 8'd0);
    seen = 0;
    repeat (600) begin @(negedge clk); if (wdt_rst) seen = 1; end
    chk("R6 no pulse while stopped", seen, 0);

    // R11 source codes
    wr(2'd0, 8'h04); delta(12, 24, d); chk("R11 div4 rate", d, 6);
    wr(2'd0, 8'h08);
    begin
      logic [15:0] c0;
      c0 = count;
      repeat (5) begin ext_tick = 1; @(negedge clk); ext_tick = 0; @(negedge clk); end
      chk("R11 external ticks", int'(count - c0), 5);
    end
    wr(2'd0, 8'h1C); delta(12, 24, d); chk("R11 code 7 as div12", d, 2);
    wr(2'd0, 8'h0C); delta(0, 24, d); chk("R11 sysclk rate", d, 24);

    // R9 idle suspend
    wr(2'd0, 8'h2C); cpu_idle = 1;
    delta(0, 20, d); chk("R9 suspended count holds", d, 0);
    cpu_idle = 0;
    delta(0, 20, d); chk("R9 resumes when not idle", d, 20);
    wr(2'd0, 8'h0C); cpu_idle = 1;
    delta(0, 20, d); chk("R9 idle ignored without bit", d, 20);
    cpu_idle = 0;

    // R8 config frozen while running
    wr(2'd1, 8'h80); wr(2'd2, 8'd0); wr(2'd0, 8'h01);
    wr(2'd0, 8'h0D); delta(12, 24, d); chk("R8 source frozen", d, 2);
    wr(2'd0, 8'h21); cpu_idle = 1;
    delta(12, 24, d); chk("R8 idle bit frozen", d, 2);
    cpu_idle = 0;

    // R10 offset frozen while running
    wr(2'd1, 8'h05);
    wr(2'd0, 8'h00); wr(2'd0, 8'h0C); wr(2'd0, 8'h0D);
    lo_v = count[7:0];
    wr(2'd2, 8'd0);
    wait_pulse(n);
    chk("R10 offset write ignored (timeout)", n, 128 * 256 + 255 - lo_v);

    // seeded random traffic against the model (R1, R2)
    repeat (4000) begin
      int r;
      r = $urandom % 64;
      ext_tick = $urandom % 2;
      cpu_idle = ($urandom % 4) == 0;
      wr_en = 1; wr_data = 8'($urandom);
      if (r < 6)       wr_addr = 2'd0;
      else if (r < 10) wr_addr = 2'd1;
      else if (r < 16) wr_addr = 2'd2;
      else if (r == 16) wr_addr = 2'd3;
      else begin wr_en = 0; wr_addr = 2'd2; end
      if (wr_addr == 2'd0 && ($urandom % 4) != 0) wr_data[1] = 1'b0;
      @(negedge clk);
    end
    wr_en = 0; ext_tick = 0; cpu_idle = 0;
    @(negedge clk);

    done = 1;
    report();
    $finish;
  end
endmodule